// File: doc/BRIEF.md
# Accumulator Processor with Addressing Modes

This block is a small multi-cycle processor built around an accumulator and a separate index register. It fetches one 16-bit instruction word at a time through a single synchronous memory read port. It then runs the instruction through a short state sequence. The instruction set covers loads, additions, subtractions and increments, and the machine stops on a halt opcode.

Operands are reached in four ways: as an immediate value held in the instruction, at a direct address, through a pointer stored in memory, or at an address offset by the index register. A pointer load makes two data reads one after the other. Every other memory-operand instruction makes one data read. The accumulator, the index register, the program counter and a halt flag are brought out on debug ports, so a host or a bench can watch the processor execute.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator, the index register and the program counter read 0 and the halt flag reads 0. Reset clears them asynchronously, and its release is synchronised in two clock stages.
- R2: An instruction word is laid out as follows. Bits [15:12] hold the opcode. Bit 11 is the register select. Bits [10:0] hold the operand, and immediate forms zero-extend it to 16 bits. The opcodes are 0 LDM, 1 LDD, 2 LDI, 3 LDX, 4 LDR, 5 ADD immediate, 6 ADD address, 7 SUB immediate, 8 SUB address, 9 INC and 15 HALT.
- R3: LDM loads the zero-extended operand into the accumulator, and LDR loads it into the index register. Neither one reads data memory, and each finishes 3 cycles after its fetch cycle begins. LDR leaves the accumulator unchanged.
- R4: LDD loads the memory word at the operand address into the accumulator and finishes in 4 cycles.
- R5: LDI reads the word at the operand address and uses its low 11 bits as a second address. It then loads the word at that second address into the accumulator and finishes in 5 cycles.
- R6: LDX loads the word at (operand + index register) modulo 2048 into the accumulator and finishes in 4 cycles.
- R7: ADD and SUB replace the accumulator with the accumulator plus or minus the operand. The operand comes from the zero-extended field in the immediate form (3 cycles) or from memory at the operand address in the address form (4 cycles). Results wrap modulo 65536.
- R8: INC with select 0 adds 1 to the accumulator, and with select 1 adds 1 to the index register. The result wraps modulo 65536, and the register not selected is left unchanged. INC takes 3 cycles.
- R9: The program counter advances by exactly one after each instruction fetch.
- R10: Opcode 15, and every opcode not listed in R2, sets the halt flag 2 cycles after the fetch cycle begins. From then until reset the program counter, the accumulator and the index register stay unchanged and the flag stays set.
- R11: Memory read data is taken one cycle after the address is driven, and the write enable output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 11 | Memory address for instruction and data reads |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable, always 0 |
| dbg_acc | output | 16 | Accumulator value |
| dbg_ix | output | 16 | Index register value |
| dbg_pc | output | 11 | Program counter value |
| dbg_halted | output | 1 | Halt flag |

## Verification
Each result is due a fixed number of clock edges after its fetch cycle begins. Immediate and increment instructions take 3 edges, single-read loads and arithmetic take 4, pointer loads take 5, and halt takes 2. The bench works out that count from the opcode of the instruction it is running. It waits exactly that many rising edges and samples the debug outputs at the falling edge that follows. That falling edge is also the first cycle of the next fetch. Any extra or missing state therefore shifts every later sample and shows up as a wrong register value or a wrong program counter.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_LDM  = 4'd0,
    OP_LDD  = 4'd1,
    OP_LDI  = 4'd2,
    OP_LDX  = 4'd3,
    OP_LDR  = 4'd4,
    OP_ADDI = 4'd5,
    OP_ADDA = 4'd6,
    OP_SUBI = 4'd7,
    OP_SUBA = 4'd8,
    OP_INC  = 4'd9,
    OP_HALT = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_READ1  = 3'd2,
    ST_READ2  = 3'd3,
    ST_EXEC   = 3'd4,
    ST_HALT   = 3'd5
  } state_e;

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_ni,
  input  opcode_e dec_op,
  input  opcode_e ir_op,
  output state_e  state
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (dec_op)
          OP_LDD, OP_LDI, OP_LDX, OP_ADDA, OP_SUBA: state_d = ST_READ1;
          OP_LDM, OP_LDR, OP_ADDI, OP_SUBI, OP_INC: state_d = ST_EXEC;
          default:                                  state_d = ST_HALT;
        endcase
      end
      ST_READ1:  state_d = (ir_op == OP_LDI) ? ST_READ2 : ST_EXEC;
      ST_READ2:  state_d = ST_EXEC;
      ST_EXEC:   state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign state = state_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_HALT) |=> (state_q == ST_HALT)); // R10

  AST_READ2_ONLY_PTR: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_READ2) |-> (ir_op == OP_LDI)); // R5

endmodule

// File: rtl/acc_cpu_agen.sv
module acc_cpu_agen
  import acc_cpu_pkg::*;
#(
  parameter int AW = 11
) (
  input  state_e        state,
  input  opcode_e       ir_op,
  input  logic [AW-1:0] opnd,
  input  logic [AW-1:0] ix_lo,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ptr,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] idx_sum;

  // Sum is kept to AW bits, so indexed addresses wrap around memory
  assign idx_sum = opnd + ix_lo;

  always_comb begin
    addr = pc;
    case (state)
      ST_READ1: addr = (ir_op == OP_LDX) ? idx_sum : opnd;
      ST_READ2: addr = ptr;
      default:  addr = pc;
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  opcode_e       op,
  input  logic          sel,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] mdata,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] ix,
  output logic [DW-1:0] acc_d,
  output logic [DW-1:0] ix_d,
  output logic          acc_wr,
  output logic          ix_wr
);

  always_comb begin
    acc_d  = acc;
    ix_d   = ix;
    acc_wr = 1'b0;
    ix_wr  = 1'b0;
    case (op)
      OP_LDM:                 begin acc_d = imm;         acc_wr = 1'b1; end
      OP_LDD, OP_LDI, OP_LDX: begin acc_d = mdata;       acc_wr = 1'b1; end
      OP_LDR:                 begin ix_d  = imm;         ix_wr  = 1'b1; end
      OP_ADDI:                begin acc_d = acc + imm;   acc_wr = 1'b1; end
      OP_ADDA:                begin acc_d = acc + mdata; acc_wr = 1'b1; end
      OP_SUBI:                begin acc_d = acc - imm;   acc_wr = 1'b1; end
      OP_SUBA:                begin acc_d = acc - mdata; acc_wr = 1'b1; end
      OP_INC: begin
        if (sel) begin ix_d  = ix + 1'b1;  ix_wr  = 1'b1; end
        else     begin acc_d = acc + 1'b1; acc_wr = 1'b1; end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = DW - OPC_W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] dbg_acc,
  output logic [DW-1:0] dbg_ix,
  output logic [AW-1:0] dbg_pc,
  output logic          dbg_halted
);

  localparam int SEL_BIT = AW;
  localparam int OPC_LSB = AW + 1;

  // Reset: asserted at once, released after two clock stages
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  state_e        state;
  logic [DW-1:0] ir_q, ir_d;
  logic          ir_en;
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;
  logic [DW-1:0] acc_q, acc_d, ix_q, ix_d;
  logic          acc_wr, ix_wr, acc_en, ix_en;
  opcode_e       ir_op, dec_op;
  logic          ir_sel;
  logic [AW-1:0] ir_opnd;
  logic [DW-1:0] imm_ext;

  assign dec_op  = opcode_e'(mem_rdata[DW-1:OPC_LSB]);
  assign ir_op   = opcode_e'(ir_q[DW-1:OPC_LSB]);
  assign ir_sel  = ir_q[SEL_BIT];
  assign ir_opnd = ir_q[AW-1:0];
  assign imm_ext = {{(DW-AW){1'b0}}, ir_opnd};

  acc_cpu_seq u_seq (
    .clk    (clk),
    .rst_ni (rst_i),
    .dec_op (dec_op),
    .ir_op  (ir_op),
    .state  (state)
  );

  acc_cpu_agen #(.AW(AW)) u_agen (
    .state (state),
    .ir_op (ir_op),
    .opnd  (ir_opnd),
    .ix_lo (ix_q[AW-1:0]),
    .pc    (pc_q),
    .ptr   (mem_rdata[AW-1:0]),
    .addr  (mem_addr)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op     (ir_op),
    .sel    (ir_sel),
    .imm    (imm_ext),
    .mdata  (mem_rdata),
    .acc    (acc_q),
    .ix     (ix_q),
    .acc_d  (acc_d),
    .ix_d   (ix_d),
    .acc_wr (acc_wr),
    .ix_wr  (ix_wr)
  );

  // Next-state and enables
  always_comb begin
    ir_en  = (state == ST_DECODE);
    ir_d   = mem_rdata;
    pc_en  = (state == ST_FETCH);
    pc_d   = pc_q + 1'b1;
    acc_en = (state == ST_EXEC) && acc_wr;
    ix_en  = (state == ST_EXEC) && ix_wr;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ir_q  <= '0;
      pc_q  <= '0;
      acc_q <= '0;
      ix_q  <= '0;
    end else begin
      if (ir_en)  ir_q  <= ir_d;
      if (pc_en)  pc_q  <= pc_d;
      if (acc_en) acc_q <= acc_d;
      if (ix_en)  ix_q  <= ix_d;
    end
  end

  assign mem_we     = 1'b0;
  assign dbg_acc    = acc_q;
  assign dbg_ix     = ix_q;
  assign dbg_pc     = pc_q;
  assign dbg_halted = (state == ST_HALT);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_FETCH) |=> (pc_q == AW'($past(pc_q) + 1'b1))); // R9

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_i)
    dbg_halted |=> ($stable(pc_q) && $stable(acc_q) && $stable(ix_q))); // R10

  AST_INC_ACC_KEEPS_IX: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_EXEC && ir_op == OP_INC && !ir_sel) |=> $stable(ix_q)); // R8

  AST_INC_IX_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_EXEC && ir_op == OP_INC && ir_sel) |=> $stable(acc_q)); // R8

  AST_LDR_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_i)
    (state == ST_EXEC && ir_op == OP_LDR) |=> $stable(acc_q)); // R3

endmodule

// File: tb/acc_cpu_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_tb_top;

  localparam int DW = 16;
  localparam int AW = 11;
  localparam int NVEC = 13;
  localparam int WATCHDOG_CYC = 5000;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;
  logic [DW-1:0] dbg_acc, dbg_ix;
  logic [AW-1:0] dbg_pc;
  logic          dbg_halted;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  int n_chk  = 0;
  int n_fail = 0;
  bit summary_done = 0;

  acc_cpu dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .dbg_acc    (dbg_acc),
    .dbg_ix     (dbg_ix),
    .dbg_pc     (dbg_pc),
    .dbg_halted (dbg_halted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Synchronous memory, one cycle of read latency
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  // {instruction, expected acc, expected ix}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0005, 16'h0005, 16'h0000},  // LDM #5
    {16'h4003, 16'h0005, 16'h0003},  // LDR #3
    {16'h1064, 16'h1234, 16'h0003},  // LDD 100
    {16'h5010, 16'h1244, 16'h0003},  // ADD #16
    {16'h6066, 16'h1344, 16'h0003},  // ADD 102
    {16'h7044, 16'h1300, 16'h0003},  // SUB #0x44
    {16'h8067, 16'hFFFF, 16'h0003},  // SUB 103, wraps below zero
    {16'h9000, 16'h0000, 16'h0003},  // INC acc, wraps to zero
    {16'h9800, 16'h0000, 16'h0004},  // INC ix
    {16'h3068, 16'h0ABC, 16'h0004},  // LDX 104 -> 108
    {16'h2065, 16'h7E57, 16'h0004},  // LDI 101 -> 200
    {16'h07FF, 16'h07FF, 16'h0004},  // LDM largest operand
    {16'hF000, 16'h07FF, 16'h0004}   // HALT
  };

  function automatic int cycles_for(input logic [3:0] op);
    case (op)
      4'd0, 4'd4, 4'd5, 4'd7, 4'd9: return 3;
      4'd1, 4'd3, 4'd6, 4'd8:       return 4;
      4'd2:                         return 5;
      default:                      return 2;
    endcase
  endfunction

  function automatic string req_for(input logic [3:0] op);
    case (op)
      4'd0, 4'd4:       return "R3";
      4'd1:             return "R4";
      4'd2:             return "R5";
      4'd3:             return "R6";
      4'd5, 4'd6, 4'd7, 4'd8: return "R7";
      4'd9:             return "R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic print_summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
  endtask

  // Releases reset at a falling edge and returns in the first fetch cycle
  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [15:0] ins);
    repeat (cycles_for(ins[15:12])) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    clear_mem();
    for (int i = 0; i < NVEC; i++) mem[i] = VEC[i][47:32];
    mem[100] = 16'h1234;
    mem[101] = 16'd200;
    mem[102] = 16'h0100;
    mem[103] = 16'h1301;
    mem[108] = 16'h0ABC;
    mem[200] = 16'h7E57;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "acc in reset", 32'(dbg_acc), 32'h0);
    chk("R1", "ix in reset", 32'(dbg_ix), 32'h0);
    chk("R1", "pc in reset", 32'(dbg_pc), 32'h0);
    chk("R1", "halted in reset", 32'(dbg_halted), 32'h0);
    release_reset();
    chk("R1", "pc after release", 32'(dbg_pc), 32'h0);

    // Vector walk: R2 encoding, R9 pc step, R11 latency and write enable
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] ins;
      string rq;
      ins = VEC[i][47:32];
      rq  = req_for(ins[15:12]);
      run_instr(ins);
      chk(rq, $sformatf("acc after vec %0d", i), 32'(dbg_acc), 32'(VEC[i][31:16]));
      chk(rq, $sformatf("ix after vec %0d", i), 32'(dbg_ix), 32'(VEC[i][15:0]));
      chk("R9", $sformatf("pc after vec %0d", i), 32'(dbg_pc), 32'(i + 1));
      chk("R2", $sformatf("halted after vec %0d", i), 32'(dbg_halted),
          32'(i == NVEC - 1));
      chk("R11", "write enable low", 32'(mem_we), 32'h0);
    end

    // R10: the halted machine stays frozen
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R10", "pc frozen", 32'(dbg_pc), 32'(NVEC));
    chk("R10", "acc frozen", 32'(dbg_acc), 32'h07FF);
    chk("R10", "halt sticky", 32'(dbg_halted), 32'h1);

    // R1: asynchronous clear in mid-run
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "acc async clear", 32'(dbg_acc), 32'h0);
    chk("R1", "ix async clear", 32'(dbg_ix), 32'h0);
    chk("R1", "pc async clear", 32'(dbg_pc), 32'h0);
    chk("R1", "halt cleared", 32'(dbg_halted), 32'h0);

    // Second program: indexed wrap, INC ix keeps acc, undefined opcode halts
    clear_mem();
    mem[0]  = 16'h47F8;  // LDR #2040
    mem[1]  = 16'h3014;  // LDX 20 -> (2060 mod 2048) = 12
    mem[2]  = 16'h9800;  // INC ix
    mem[3]  = 16'hB000;  // undefined opcode 11
    mem[12] = 16'h5A5A;
    release_reset();
    run_instr(mem[0]);
    chk("R3", "LDR ix", 32'(dbg_ix), 32'h07F8);
    chk("R3", "LDR keeps acc", 32'(dbg_acc), 32'h0);
    run_instr(mem[1]);
    chk("R6", "indexed wrap load", 32'(dbg_acc), 32'h5A5A);
    run_instr(mem[2]);
    chk("R8", "INC ix value", 32'(dbg_ix), 32'h07F9);
    chk("R8", "INC ix keeps acc", 32'(dbg_acc), 32'h5A5A);
    run_instr(mem[3]);
    chk("R10", "undefined opcode halts", 32'(dbg_halted), 32'h1);
    chk("R10", "pc after undefined", 32'(dbg_pc), 32'h4);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R10", "pc stays", 32'(dbg_pc), 32'h4);
    chk("R10", "ix stays", 32'(dbg_ix), 32'h07F9);

    print_summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    print_summary();
    $finish;
  end

endmodule